// File: doc/BRIEF.md
# Watchdog Timer with Paired Software Clear

This block is a watchdog for a small microcontroller core. It counts enable pulses from one of two tick sources picked by a configuration strap. The first source is an internal oscillator tick. The second is the system clock divided by four. Ticks advance a free-running prescaler of `DIV_BITS` bits. Each prescaler carry toggles a one-bit final stage. A carry that arrives while the final stage is already set is a time-out.

Software keeps the watchdog quiet by issuing clear strobes, and a halt strobe also clears it. A clear resets only the final stage and leaves the prescaler alone. The interval after a clear therefore depends on what the prescaler held at that moment, and it can vary by a factor of two.

A strap selects how software clears the watchdog. In single mode one command is enough. In paired mode two distinct commands are needed, and they may come in either order.

On a time-out in normal operation the block pulses a full device reset request. On a time-out in power-down it pulses a partial reset request instead. In both cases it sets a sticky time-out flag. The reset input is synchronous and active high; it stands for the external reset after the pad inversion.

Top module: `wdog_timer`

## Requirements
- R1: With `cfg_src_sys`=0 the counter advances once per cycle in which `osc_tick` is 1. With `cfg_src_sys`=1 it ignores `osc_tick` and advances on every fourth clock; the first tick after reset release is taken on the 4th rising edge.
- R2: After reset release, the first time-out occurs on the 2^(DIV_BITS+1)-th counted tick. After that, time-outs repeat every 2^(DIV_BITS+1) ticks while no clear occurs.
- R3: A clear resets only the final stage. If the prescaler holds d (= ticks since reset modulo 2^DIV_BITS) after the clearing edge, the next time-out comes 2^(DIV_BITS+1) − d ticks later.
- R4: With `cfg_en`=0, counting stops, no reset request is produced, and `clr_a`, `clr_b` and `halt` have no effect; in particular they leave `to_flag` unchanged.
- R5: With `cfg_pair`=0, a `clr_a` strobe clears the watchdog and clears `to_flag`. A `clr_b` strobe has no effect.
- R6: With `cfg_pair`=1, the watchdog clears only when one of `clr_a`/`clr_b` follows the other, in either order, or when both arrive in the same cycle. Repeating the same strobe does nothing.
- R7: A time-out with `pwr_down`=0 raises `sys_rst_req` for exactly one cycle, in the cycle after the timing-out tick edge, and sets `to_flag`.
- R8: A time-out with `pwr_down`=1 raises `pc_rst_req` for one cycle and sets `to_flag`; `sys_rst_req` stays 0.
- R9: Reset clears the prescaler, the final stage, `to_flag`, the pending half-clear and both requests. A `halt` strobe clears the final stage, `to_flag` and the pending half-clear.
- R10: With `cfg_src_sys`=1 and `pwr_down`=1 the divided tick stops, so no time-out can occur.
- R11: `to_flag` stays 1 after a time-out until reset, a successful clear or `halt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (external reset) |
| osc_tick | input | 1 | One-cycle pulse from the internal oscillator |
| cfg_en | input | 1 | Strap: watchdog enabled |
| cfg_src_sys | input | 1 | Strap: 1 selects clock/4 tick, 0 selects oscillator tick |
| cfg_pair | input | 1 | Strap: 1 selects paired clear mode |
| clr_a | input | 1 | Software clear command A (the only command in single mode) |
| clr_b | input | 1 | Software clear command B (paired mode only) |
| halt | input | 1 | Halt strobe; also clears the watchdog |
| pwr_down | input | 1 | Core is in power-down |
| sys_rst_req | output | 1 | One-cycle full device reset request |
| pc_rst_req | output | 1 | One-cycle partial reset request (program counter and stack) |
| to_flag | output | 1 | Sticky time-out flag |

## Verification
The assertions watch, on every cycle, that requests last one cycle and never both fire. They also check that a full request never follows a power-down cycle, that a disabled watchdog stays silent, and that a request always comes with the flag. Inside the blocks they check that a clear drops the final stage while leaving the prescaler, that halt empties the pending half-clear, and that the divider holds in power-down. The timing of each time-out is shown only by the bench scenarios, which predict the exact cycle of every request. These cover the residual-prescaler effect of a clear, both pairing orders, repeated same-command strobes, halt cancelling a half-clear, the clock/4 source, and the frozen source in power-down.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_A    = 2'd1,
    PEND_B    = 2'd2
  } pend_e;
endpackage

// File: rtl/wdt_tick_src.sv
module wdt_tick_src #(
  parameter int PRE_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_down,
  input  logic osc_tick,
  input  logic src_sys,
  output logic tick
);
  logic sys_tick;

  generate
    if (PRE_DIV > 1) begin : g_div
      localparam int PRE_W = $clog2(PRE_DIV);
      localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_DIV - 1);
      logic [PRE_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (!pwr_down) begin
          if (cnt_q == LAST) cnt_q <= '0;
          else               cnt_q <= cnt_q + 1'b1;
        end
      end

      assign sys_tick = (cnt_q == LAST) && !pwr_down;

      // R10: the divided clock stands still in power-down
      p_div_hold_r10: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> cnt_q == $past(cnt_q));
    end else begin : g_nodiv
      assign sys_tick = !pwr_down;
    end
  endgenerate

  assign tick = src_sys ? sys_tick : osc_tick;
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int DIV_BITS = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clr,
  output logic expire
);
  logic [DIV_BITS-1:0] div_q;
  logic                stage_q;
  logic                carry;

  assign carry  = &div_q;
  assign expire = tick && carry && stage_q && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      stage_q <= 1'b0;
    end else begin
      if (tick) div_q <= div_q + 1'b1;
      if (clr)                 stage_q <= 1'b0;
      else if (tick && carry)  stage_q <= ~stage_q;
    end
  end

  // R3: a clear empties the final stage
  p_stage_clr_r3: assert property (@(posedge clk) disable iff (rst)
    clr |=> !stage_q);
  // R3: a clear alone leaves the prescaler untouched
  p_div_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (clr && !tick) |=> div_q == $past(div_q));
endmodule

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pair,
  input  logic clr_a,
  input  logic clr_b,
  input  logic halt,
  output logic clr
);
  pend_e pend_q, pend_d;
  logic  sw_ok;

  always_comb begin
    pend_d = pend_q;
    sw_ok  = 1'b0;
    if (!en) begin
      pend_d = pend_q;
    end else if (halt) begin
      pend_d = PEND_NONE;
    end else if (!pair) begin
      pend_d = PEND_NONE;
      sw_ok  = clr_a;
    end else if (clr_a && clr_b) begin
      pend_d = PEND_NONE;
      sw_ok  = 1'b1;
    end else if (clr_a) begin
      if (pend_q == PEND_B) begin
        pend_d = PEND_NONE;
        sw_ok  = 1'b1;
      end else begin
        pend_d = PEND_A;
      end
    end else if (clr_b) begin
      if (pend_q == PEND_A) begin
        pend_d = PEND_NONE;
        sw_ok  = 1'b1;
      end else begin
        pend_d = PEND_B;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= PEND_NONE;
    else     pend_q <= pend_d;
  end

  assign clr = en && (halt || sw_ok);

  // R6: the half-clear record never holds an unused code
  p_pend_valid_r6: assert property (@(posedge clk) disable iff (rst)
    pend_q != pend_e'(2'd3));
  // R9: halt drops any half-done pairing
  p_halt_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (en && halt) |=> pend_q == PEND_NONE);
  // R5: single mode keeps nothing pending
  p_single_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !pair) |=> pend_q == PEND_NONE);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int DIV_BITS = 15,
  parameter int PRE_DIV  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_tick,
  input  logic cfg_en,
  input  logic cfg_src_sys,
  input  logic cfg_pair,
  input  logic clr_a,
  input  logic clr_b,
  input  logic halt,
  input  logic pwr_down,
  output logic sys_rst_req,
  output logic pc_rst_req,
  output logic to_flag
);
  logic src_tick;
  logic tick;
  logic clr;
  logic expire;

  wdt_tick_src #(.PRE_DIV(PRE_DIV)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .pwr_down (pwr_down),
    .osc_tick (osc_tick),
    .src_sys  (cfg_src_sys),
    .tick     (src_tick)
  );

  assign tick = cfg_en && src_tick;

  wdt_clear_ctl u_clr (
    .clk   (clk),
    .rst   (rst),
    .en    (cfg_en),
    .pair  (cfg_pair),
    .clr_a (clr_a),
    .clr_b (clr_b),
    .halt  (halt),
    .clr   (clr)
  );

  wdt_count #(.DIV_BITS(DIV_BITS)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .clr    (clr),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_req <= 1'b0;
      pc_rst_req  <= 1'b0;
      to_flag     <= 1'b0;
    end else begin
      sys_rst_req <= expire && !pwr_down;
      pc_rst_req  <= expire && pwr_down;
      if (clr)         to_flag <= 1'b0;
      else if (expire) to_flag <= 1'b1;
    end
  end

  // R7: full reset request lasts one cycle
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |=> !sys_rst_req);
  // R8: never both request kinds together
  p_req_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(sys_rst_req && pc_rst_req));
  // R8: no full reset request out of a power-down cycle
  p_pd_no_full_r8: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> $past(!pwr_down));
  // R4: a disabled watchdog raises nothing
  p_off_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> !sys_rst_req && !pc_rst_req);
  // R11: every request comes with the flag
  p_flag_set_r11: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_req || pc_rst_req) |-> to_flag);
  // R9: halt on an enabled watchdog drops the flag
  p_halt_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && halt) |=> !to_flag);
endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DIVB = 6;
  localparam int FULL = 1 << (DIVB + 1);
  localparam int HALF = 1 << DIVB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_tick = 1'b0, cfg_en = 1'b1, cfg_src_sys = 1'b0, cfg_pair = 1'b0;
  logic clr_a = 1'b0, clr_b = 1'b0, halt = 1'b0, pwr_down = 1'b0;
  logic sys_rst_req, pc_rst_req, to_flag;

  typedef struct { int cyc; bit part; } exp_t;
  exp_t exp_q[$];

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int c0 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_timer #(.DIV_BITS(DIVB), .PRE_DIV(4)) i_wdog_timer (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .cfg_en(cfg_en),
    .cfg_src_sys(cfg_src_sys), .cfg_pair(cfg_pair), .clr_a(clr_a),
    .clr_b(clr_b), .halt(halt), .pwr_down(pwr_down),
    .sys_rst_req(sys_rst_req), .pc_rst_req(pc_rst_req), .to_flag(to_flag)
  );

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Monitor: every request pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && (sys_rst_req || pc_rst_req)) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2/R4/R10 unexpected request at T=%0d: actual sys=%0b pc=%0b expected none",
                 cyc - c0, sys_rst_req, pc_rst_req);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.cyc != cyc || pc_rst_req != e.part || sys_rst_req == e.part) begin
          errors++;
          $display("FAIL R2/R3/R7/R8 request: actual T=%0d sys=%0b pc=%0b expected T=%0d part=%0b",
                   cyc - c0, sys_rst_req, pc_rst_req, e.cyc - c0, e.part);
        end
      end
    end
  end

  task automatic expect_at(input int t, input bit part);
    exp_t e;
    e.cyc = c0 + t;
    e.part = part;
    exp_q.push_back(e);
  endtask

  task automatic go_to(input int t);
    while (cyc < c0 + t - 1) @(negedge clk);
  endtask

  // strobe lands on the edge with T = t
  task automatic strobe(input int t, input int which);
    go_to(t);
    if (which == 0) clr_a = 1'b1;
    else if (which == 1) clr_b = 1'b1;
    else halt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr_a = 1'b0; clr_b = 1'b0; halt = 1'b0;
  endtask

  task automatic do_reset(input logic en, input logic src, input logic pair,
                          input logic pd, input logic osc);
    rst = 1'b1;
    cfg_en = en; cfg_src_sys = src; cfg_pair = pair; pwr_down = pd; osc_tick = osc;
    clr_a = 1'b0; clr_b = 1'b0; halt = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 reset sys_rst_req", sys_rst_req, 0);
    chk("R9 reset pc_rst_req", pc_rst_req, 0);
    chk("R9 reset to_flag", to_flag, 0);
    exp_q.delete();
    rst = 1'b0;
    c0 = cyc;
  endtask

  task automatic drained(input string tag);
    chk(tag, exp_q.size(), 0);
  endtask

  initial begin
    @(negedge clk);
    // S1/S2: oscillator source, first time-out from reset
    do_reset(1, 0, 0, 0, 1);
    expect_at(FULL, 0);
    go_to(FULL - 2);
    chk("R11 flag low before time-out", to_flag, 0);
    go_to(FULL + 2);
    drained("R1 R2 R7 first time-out from reset");
    chk("R7 flag set by time-out", to_flag, 1);
    // S3: single clear leaves prescaler residue (T=200 -> d=8)
    go_to(199);
    chk("R11 flag held", to_flag, 1);
    strobe(200, 0);
    chk("R5 clr_a clears flag", to_flag, 0);
    expect_at(200 + FULL - (200 % HALF), 0);
    go_to(330);
    drained("R3 R5 residue timing after clr_a");
    // S4: clr_b ignored in single mode
    strobe(400, 1);
    chk("R5 clr_b leaves flag", to_flag, 1);
    expect_at(448, 0);
    go_to(450);
    drained("R5 clr_b ignored in single mode");

    // S5: paired, A A B
    do_reset(1, 0, 1, 0, 1);
    expect_at(FULL, 0);
    go_to(FULL + 2);
    drained("R2 paired-mode first time-out");
    strobe(140, 0);
    chk("R6 lone clr_a no clear", to_flag, 1);
    strobe(150, 0);
    chk("R6 repeated clr_a no clear", to_flag, 1);
    strobe(200, 1);
    chk("R6 clr_b completes pair", to_flag, 0);
    expect_at(200 + FULL - (200 % HALF), 0);
    go_to(322);
    drained("R6 timing after A-A-B");
    // S6: paired, B then A
    strobe(330, 1);
    chk("R6 lone clr_b no clear", to_flag, 1);
    strobe(400, 0);
    chk("R6 clr_a completes B-A", to_flag, 0);
    expect_at(400 + FULL - (400 % HALF), 0);
    go_to(514);
    drained("R6 timing after B-A");

    // S7: halt clears stage and cancels half-clear
    do_reset(1, 0, 1, 0, 1);
    strobe(20, 0);
    strobe(100, 2);
    strobe(150, 1);
    expect_at(100 + FULL - (100 % HALF), 0);
    go_to(194);
    drained("R9 halt cancels pending clr_a");
    chk("R7 flag after time-out", to_flag, 1);
    strobe(200, 2);
    chk("R9 halt clears flag", to_flag, 0);
    expect_at(200 + FULL - (200 % HALF), 0);
    go_to(322);
    drained("R9 halt timing");

    // S8: power-down with oscillator source
    do_reset(1, 0, 0, 1, 1);
    expect_at(FULL, 1);
    go_to(FULL + 2);
    drained("R8 partial request in power-down");
    chk("R8 flag set in power-down", to_flag, 1);

    // S9: clock/4 source, oscillator ignored
    do_reset(1, 1, 0, 0, 1);
    expect_at(4 * FULL, 0);
    go_to(4 * FULL + 2);
    drained("R1 clock/4 source timing");

    // S10: clock/4 frozen in power-down
    do_reset(1, 1, 0, 1, 0);
    go_to(4 * FULL + 200);
    chk("R10 no time-out while frozen", to_flag, 0);
    drained("R10 frozen source");

    // S11: disable
    do_reset(1, 0, 0, 0, 1);
    expect_at(FULL, 0);
    go_to(FULL + 2);
    drained("R2 time-out before disable");
    cfg_en = 1'b0;
    strobe(140, 0);
    chk("R4 clr_a ignored when disabled", to_flag, 1);
    strobe(150, 2);
    chk("R4 halt ignored when disabled", to_flag, 1);
    go_to(150 + 3 * FULL);
    chk("R4 no request while disabled", sys_rst_req | pc_rst_req, 0);
    drained("R4 disabled stays quiet");

    // final reset clears flag
    do_reset(1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R9 flag after reset", to_flag, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule